// File: doc/BRIEF.md
# Indirect GPIO Port Register Bank

This block is the register side of a bank of general-purpose I/O ports on an 8-bit microcontroller bus. Every port takes a four-byte slot in a small address window. The first byte of the slot is an index register. The second byte is a data window that reaches whichever sub-register the index currently names. The third byte is a read-only view of the port's pins, taken after a two-flop synchronizer. The fourth byte is reserved.

Software uses a sub-register in two steps. It first writes the index, then reads or writes the window as often as it needs. The bank holds three sub-registers per port: a per-pin alternate-function enable, a first alternate-function set and a second alternate-function set. From these, each pin gets an effective enable and a 2-bit set selection that go to the peripheral multiplexers.

A parameter mask marks which ports exist in the configured package. Every location of a missing port reads zero and ignores writes. A second parameter selects the small-package configuration. In that configuration the second set of port A resets to 04h.

Top module: `gpio_ibank`

## Requirements
- R1: Port p occupies bus addresses BASE+4p to BASE+4p+3, with BASE = FD0h. Offset 0 is the index, offset 1 is the data window, offset 2 is the pin input and offset 3 is reserved and reads 00h. An address outside the window reads 00h. `bus_rdata` is 00h whenever `bus_rd` is low.
- R2: The index register resets to 00h and reads back its value. It keeps that value until it is written again, so repeated window accesses reach the same sub-register.
- R3: Index 08h selects the second alternate-function set. All eight bits can be written and read back through the window.
- R4: Index 02h selects the alternate-function enable and index 07h selects the first alternate-function set. Both reset to 00h, and all eight bits can be written and read back.
- R5: The second set resets to 00h on every port. When SMALL_PKG is 1, port A's second set resets to 04h instead.
- R6: A window access with any other index reads 00h. A write through such an index leaves all three sub-registers unchanged.
- R7: The pin input register returns the port's pin levels as sampled two clock edges earlier. A write to it is ignored.
- R8: A port whose PORT_MASK bit is 0 reads 00h at all four offsets and ignores writes. Its `af_en` and `af_sel` outputs stay at 0.
- R9: For pin b of a present port p, `af_en[8p+b]` equals bit b of the enable. `af_sel[2(8p+b)+1 : 2(8p+b)]` equals {second-set bit, first-set bit} when that enable bit is 1, and 00 otherwise.
- R10: A write takes effect at the clock edge that accepts it. The next cycle's read and the select outputs show the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pin_in | input | NUM_PORTS*8 | Asynchronous pin levels, port p in bits 8p+7:8p |
| af_en | output | NUM_PORTS*8 | Effective alternate-function enable per pin |
| af_sel | output | NUM_PORTS*16 | Two-bit set selection per pin |

## Verification
Pin sampling runs on every clock, so a bus write to a sub-register and a change on the pins can land in the same cycle. The bench provokes this by toggling the pins on every cycle while it writes the second set and the enable at random indices and ports. It also reads the pin register right after such writes. A behavioural model holds the sub-register values and a two-entry pin history, and it judges the read data and both select outputs after every clock. This shows that neither path disturbs the other and that the sampling latency stays at two edges.

// File: rtl/gpio_ibank_pkg.sv
package gpio_ibank_pkg;
  // Byte offsets inside a port slot
  localparam logic [1:0] OFF_IDX = 2'd0;
  localparam logic [1:0] OFF_WIN = 2'd1;
  localparam logic [1:0] OFF_PIN = 2'd2;

  // Sub-register indices reached through the window
  localparam logic [7:0] SUB_AFEN = 8'h02;
  localparam logic [7:0] SUB_SET1 = 8'h07;
  localparam logic [7:0] SUB_SET2 = 8'h08;

  // Per-pin selection code: {set2, set1} when enabled, else zero
  function automatic logic [1:0] pin_sel(logic en, logic s1, logic s2);
    return en ? {s2, s1} : 2'b00;
  endfunction

  // Reset value of the second set for a given port
  function automatic logic [7:0] set2_reset(bit small_pkg, int port);
    return (small_pkg && port == 0) ? 8'h04 : 8'h00;
  endfunction

  function automatic logic is_sub(logic [7:0] idx);
    return (idx == SUB_AFEN) || (idx == SUB_SET1) || (idx == SUB_SET2);
  endfunction
endpackage

// File: rtl/gpio_ibank_decode.sv
module gpio_ibank_decode #(
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE    = 12'hFD0,
  parameter int              NUM_PORTS = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_PORTS-1:0] port_hit,
  output logic [1:0]         offset
);
  logic win_hit;
  assign win_hit = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
  assign offset  = addr[1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
    assign port_hit[p] = win_hit && (addr[3:2] == 2'(p));
  end
endmodule

// File: rtl/gpio_ibank_port.sv
module gpio_ibank_port
  import gpio_ibank_pkg::*;
#(
  parameter int PORT_NUM  = 0,
  parameter bit PRESENT   = 1'b1,
  parameter bit SMALL_PKG = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sel,
  input  logic        wr,
  input  logic [1:0]  offset,
  input  logic [7:0]  wdata,
  input  logic [7:0]  pins,
  output logic [7:0]  rdata,
  output logic [7:0]  af_en,
  output logic [15:0] af_sel,
  output logic [7:0]  idx_o,
  output logic [7:0]  samp_o,
  output logic        idx_wr_o
);
  localparam logic [7:0] SET2_RST = set2_reset(SMALL_PKG, PORT_NUM);

  logic       acc, idx_wr, win_wr;
  logic [7:0] idx_q, en_q, set1_q, set2_q;
  logic [7:0] sync_a, sync_b;
  logic [7:0] win_val;

  assign acc    = sel && PRESENT;
  assign idx_wr = acc && wr && (offset == OFF_IDX);
  assign win_wr = acc && wr && (offset == OFF_WIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= 8'h00;
      en_q   <= 8'h00;
      set1_q <= 8'h00;
      set2_q <= SET2_RST;
    end else begin
      if (idx_wr) idx_q <= wdata;
      if (win_wr) begin
        case (idx_q)
          SUB_AFEN: en_q   <= wdata;
          SUB_SET1: set1_q <= wdata;
          SUB_SET2: set2_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  // Two-flop pin synchronizer, no reset: it follows the pins
  always_ff @(posedge clk) begin
    sync_a <= pins;
    sync_b <= sync_a;
  end

  always_comb begin
    case (idx_q)
      SUB_AFEN: win_val = en_q;
      SUB_SET1: win_val = set1_q;
      SUB_SET2: win_val = set2_q;
      default:  win_val = 8'h00;
    endcase
  end

  always_comb begin
    rdata = 8'h00;
    if (acc) begin
      case (offset)
        OFF_IDX: rdata = idx_q;
        OFF_WIN: rdata = win_val;
        OFF_PIN: rdata = sync_b;
        default: rdata = 8'h00;
      endcase
    end
  end

  for (genvar b = 0; b < 8; b++) begin : g_pin
    assign af_en[b]          = PRESENT && en_q[b];
    assign af_sel[2*b +: 2]  = pin_sel(af_en[b], set1_q[b], set2_q[b]);
  end

  assign idx_o    = idx_q;
  assign samp_o   = PRESENT ? sync_b : 8'h00;
  assign idx_wr_o = idx_wr;
endmodule

// File: rtl/gpio_ibank.sv
module gpio_ibank #(
  parameter int                  ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]   BASE      = 12'hFD0,
  parameter int                  NUM_PORTS = 4,
  parameter logic [NUM_PORTS-1:0] PORT_MASK = 4'b0111,
  parameter bit                  SMALL_PKG = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  input  logic [NUM_PORTS*8-1:0]  pin_in,
  output logic [NUM_PORTS*8-1:0]  af_en,
  output logic [NUM_PORTS*16-1:0] af_sel
);
  logic [NUM_PORTS-1:0]   port_hit;
  logic [1:0]             offset;
  logic [7:0]             port_rd [NUM_PORTS];
  // Named internal events for the checker
  logic [NUM_PORTS*8-1:0] idx_flat;
  logic [NUM_PORTS*8-1:0] samp_flat;
  logic [NUM_PORTS-1:0]   idx_wr_vec;

  gpio_ibank_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NUM_PORTS(NUM_PORTS)) u_dec (
    .addr     (bus_addr),
    .port_hit (port_hit),
    .offset   (offset)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_ibank_port #(
      .PORT_NUM  (p),
      .PRESENT   (PORT_MASK[p]),
      .SMALL_PKG (SMALL_PKG)
    ) u_port (
      .clk      (clk),
      .rst      (rst),
      .sel      (port_hit[p]),
      .wr       (bus_wr),
      .offset   (offset),
      .wdata    (bus_wdata),
      .pins     (pin_in[8*p +: 8]),
      .rdata    (port_rd[p]),
      .af_en    (af_en[8*p +: 8]),
      .af_sel   (af_sel[16*p +: 16]),
      .idx_o    (idx_flat[8*p +: 8]),
      .samp_o   (samp_flat[8*p +: 8]),
      .idx_wr_o (idx_wr_vec[p])
    );
  end

  always_comb begin
    logic [7:0] merged;
    merged = 8'h00;
    for (int p = 0; p < NUM_PORTS; p++) merged |= port_rd[p];
    bus_rdata = bus_rd ? merged : 8'h00;
  end
endmodule

// File: rtl/gpio_ibank_chk.sv
module gpio_ibank_chk #(
  parameter int                   NUM_PORTS = 4,
  parameter logic [NUM_PORTS-1:0] PORT_MASK = 4'b0111
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_rd,
  input logic [7:0]              bus_rdata,
  input logic [NUM_PORTS*8-1:0]  pin_in,
  input logic [NUM_PORTS*8-1:0]  af_en,
  input logic [NUM_PORTS*16-1:0] af_sel,
  input logic [NUM_PORTS*8-1:0]  idx_flat,
  input logic [NUM_PORTS*8-1:0]  samp_flat,
  input logic [NUM_PORTS-1:0]    idx_wr_vec
);
  function automatic logic [NUM_PORTS*8-1:0] byte_mask();
    logic [NUM_PORTS*8-1:0] m;
    m = '0;
    for (int p = 0; p < NUM_PORTS; p++) if (PORT_MASK[p]) m[8*p +: 8] = 8'hFF;
    return m;
  endfunction
  localparam logic [NUM_PORTS*8-1:0] PMASK8 = byte_mask();

  assert_idle_rdata_R1: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |-> bus_rdata == 8'h00);

  assert_idx_reset_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> idx_flat == '0);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_idx
    assert_idx_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !idx_wr_vec[p] |=> $stable(idx_flat[8*p +: 8]));
  end

  assert_sync_lat_R7: assert property (@(posedge clk) disable iff (rst)
    samp_flat == ($past(pin_in, 2) & PMASK8));

  assert_absent_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (af_en & ~PMASK8) == '0);

  for (genvar i = 0; i < NUM_PORTS*8; i++) begin : g_gate
    assert_sel_gated_R9: assert property (@(posedge clk) disable iff (rst)
      !af_en[i] |-> af_sel[2*i +: 2] == 2'b00);
  end
endmodule

bind gpio_ibank gpio_ibank_chk #(.NUM_PORTS(NUM_PORTS), .PORT_MASK(PORT_MASK)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .pin_in     (pin_in),
  .af_en      (af_en),
  .af_sel     (af_sel),
  .idx_flat   (idx_flat),
  .samp_flat  (samp_flat),
  .idx_wr_vec (idx_wr_vec)
);

// File: tb/gpio_ibank_tb.sv
module gpio_ibank_tb;
  localparam logic [3:0] PMASK = 4'b0111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = 12'h000;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata, rdata_s;
  logic [31:0] pin_in = 32'h0;
  logic [31:0] af_en, af_en_s;
  logic [63:0] af_sel, af_sel_s;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_ibank #(.PORT_MASK(PMASK), .SMALL_PKG(1'b0)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .af_en(af_en), .af_sel(af_sel));

  gpio_ibank #(.PORT_MASK(PMASK), .SMALL_PKG(1'b1)) u_dut_s (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .pin_in(pin_in),
    .af_en(af_en_s), .af_sel(af_sel_s));

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_idx [4], m_en [4], m_s1 [4], m_s2 [4];
  logic [31:0] hist [$];

  always @(posedge clk) begin
    hist.push_back(pin_in);
    if (hist.size() > 2) void'(hist.pop_front());
    if (rst) begin
      for (int p = 0; p < 4; p++) begin
        m_idx[p] = 0; m_en[p] = 0; m_s1[p] = 0; m_s2[p] = 0;
      end
    end else if (bus_wr && bus_addr[11:4] == 8'hFD && PMASK[bus_addr[3:2]]) begin
      int p;
      p = int'(bus_addr[3:2]);
      if (bus_addr[1:0] == 2'd0) m_idx[p] = bus_wdata;
      else if (bus_addr[1:0] == 2'd1) begin
        if (m_idx[p] == 8'h02) m_en[p] = bus_wdata;
        else if (m_idx[p] == 8'h07) m_s1[p] = bus_wdata;
        else if (m_idx[p] == 8'h08) m_s2[p] = bus_wdata;
      end
    end
  end

  function automatic logic [7:0] model_read(logic [11:0] a);
    int p;
    if (a[11:4] != 8'hFD) return 8'h00;
    p = int'(a[3:2]);
    if (!PMASK[p]) return 8'h00;
    case (a[1:0])
      2'd0: return m_idx[p];
      2'd1: return (m_idx[p] == 8'h02) ? m_en[p] :
                   (m_idx[p] == 8'h07) ? m_s1[p] :
                   (m_idx[p] == 8'h08) ? m_s2[p] : 8'h00;
      2'd2: return hist[0][8*p +: 8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] model_en();
    logic [31:0] v = '0;
    for (int p = 0; p < 4; p++) if (PMASK[p]) v[8*p +: 8] = m_en[p];
    return v;
  endfunction

  function automatic logic [63:0] model_sel();
    logic [63:0] v = '0;
    for (int p = 0; p < 4; p++)
      for (int b = 0; b < 8; b++)
        if (PMASK[p] && m_en[p][b]) v[2*(8*p+b) +: 2] = {m_s2[p][b], m_s1[p][b]};
    return v;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Every-cycle comparison, well after the rising edge
  always @(negedge clk) begin
    #3;
    if (!rst && hist.size() == 2 && !done) begin
      check("R9 af_en", 64'(af_en), 64'(model_en()));
      check("R9 af_sel", af_sel, model_sel());
      if (bus_rd) check("R10 rdata model", 64'(bus_rdata), 64'(model_read(bus_addr)));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
    #4 check(tag, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired got hang expected finish");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    pin_in = 32'h1234_5678;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R2 / R4 / R5 reset values
    rd(12'hFD0, 8'h00, "R2 index reset");
    wr(12'hFD0, 8'h08);
    rd(12'hFD1, 8'h00, "R5 set2 reset port A");
    check("R5 small package set2 reset", 64'(rdata_s), 64'h04);
    wr(12'hFD0, 8'h02);
    rd(12'hFD1, 8'h00, "R4 enable reset");
    wr(12'hFD0, 8'h07);
    rd(12'hFD1, 8'h00, "R4 set1 reset");

    // R3 / R4 read-write through the window
    wr(12'hFD1, 8'h3C);
    rd(12'hFD1, 8'h3C, "R4 set1 rw R10");
    wr(12'hFD0, 8'h08);
    wr(12'hFD1, 8'hA5);
    rd(12'hFD1, 8'hA5, "R3 set2 rw");
    wr(12'hFD1, 8'h5A);
    rd(12'hFD1, 8'h5A, "R3 set2 rw second pattern");
    wr(12'hFD0, 8'h02);
    wr(12'hFD1, 8'hF0);
    rd(12'hFD1, 8'hF0, "R4 enable rw");

    // R9 explicit pin selections on port A
    idle(); #4;
    check("R9 pin4 sel", 64'(af_sel[9:8]), 64'(2'b11));
    check("R9 pin5 sel", 64'(af_sel[11:10]), 64'(2'b01));
    check("R9 pin0 disabled", 64'(af_sel[1:0]), 64'(2'b00));
    check("R9 enable byte", 64'(af_en[7:0]), 64'hF0);

    // R6 unimplemented index
    wr(12'hFD0, 8'h05);
    wr(12'hFD1, 8'hFF);
    rd(12'hFD1, 8'h00, "R6 unimplemented reads zero");
    rd(12'hFD0, 8'h05, "R2 index held");
    rd(12'hFD0, 8'h05, "R2 index held again");
    wr(12'hFD0, 8'h08);
    rd(12'hFD1, 8'h5A, "R6 set2 untouched");
    wr(12'hFD0, 8'h07);
    rd(12'hFD1, 8'h3C, "R6 set1 untouched");
    wr(12'hFD0, 8'h02);
    rd(12'hFD1, 8'hF0, "R6 enable untouched");

    // R7 input sampling latency and read-only
    @(negedge clk); pin_in[7:0] = 8'h11;
    rd(12'hFD2, 8'h78, "R7 old sample after one edge");
    rd(12'hFD2, 8'h11, "R7 new sample after two edges");
    @(negedge clk); pin_in[15:8] = 8'hC3;
    idle(); idle();
    rd(12'hFD6, 8'hC3, "R7 port B pins");
    wr(12'hFD6, 8'h00);
    rd(12'hFD6, 8'hC3, "R7 write ignored");

    // R8 absent port D
    pin_in[31:24] = 8'hFF;
    wr(12'hFDC, 8'h02);
    wr(12'hFDD, 8'hFF);
    rd(12'hFDC, 8'h00, "R8 absent index");
    rd(12'hFDD, 8'h00, "R8 absent window");
    rd(12'hFDE, 8'h00, "R8 absent pins");
    check("R8 absent outputs", 64'(af_en[31:24]), 64'h00);

    // R1 decode edges
    rd(12'hFD3, 8'h00, "R1 reserved offset");
    rd(12'hFE0, 8'h00, "R1 outside window");
    rd(12'hDD0, 8'h00, "R1 outside window high bits");
    idle(); #4;
    check("R1 idle rdata", 64'(bus_rdata), 64'h00);

    // Concurrent pin toggling with random bus traffic (model compares each cycle)
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [7:0]  d;
      int k;
      pin_in = $urandom;
      k = $urandom_range(0, 9);
      a = {8'hFD, 4'($urandom_range(0, 15))};
      if (k < 2) d = (k == 0) ? 8'h08 : 8'h02;
      else if (k == 2) d = 8'h07;
      else d = 8'($urandom);
      if ($urandom_range(0, 1) == 0) wr(a, d);
      else begin
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
      end
    end
    idle(); idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule